// File: doc/BRIEF.md
# Pseudorandom Pixel Address Sequencer

This block visits every coordinate of a rectangle exactly once, in a scrambled order with no repeats, so that a frame can be painted one pixel at a time in a pattern that looks random. A 17-bit maximal-length Galois shift register steps through all 131071 nonzero states. Each state is split into a 9-bit column and an 8-bit row, and the block offers a coordinate only when both fields fall inside the configured limits.

A run begins with a `start` pulse. While a run is active, each state that falls inside the limits is shown on the output with `coord_valid` and is held until the downstream side raises `coord_ready`. A state outside the limits is dropped, and the register moves on by one step per clock with `coord_valid` low. When the register comes back to its seed, the run ends and `done` rises. `done` then stays high until the next start. The limits must be held stable while a run is active.

Top module: `pixscan_seq`

## Requirements
- R1: After a synchronous reset with `rst_n` low, `busy`, `done` and `coord_valid` are all 0.
- R2: A `start` pulse while idle loads the 17-bit state with 1. The first coordinate offered is therefore column 0, row 0.
- R3: Each step shifts the state right by one. If the bit shifted out was 1, the result is then XORed with 0x12000 (bits 16 and 13).
- R4: The row is the state's bits 7:0 minus one, wrapping modulo 256. The column is the state's bits 16:8.
- R5: A coordinate is offered only when column <= `col_limit` and row <= `row_limit`. A row that wrapped to 255 is therefore dropped unless `row_limit` is 255.
- R6: While `coord_valid` is high and `coord_ready` is low, the state does not advance and `coord_col` and `coord_row` stay stable.
- R7: A state outside the limits advances on the next clock with `coord_valid` low, whatever the value of `coord_ready`.
- R8: The run ends on the step that returns the state to 1, after exactly 131071 steps. At that point `busy` falls and `done` rises, and `done` stays high until the next start. `busy` and `done` are never high together.
- R9: `start` asserted while `busy` is high has no effect on the sequence.
- R10: With limits 319 and 199, the run offers exactly 64000 coordinates, all distinct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a run (ignored while busy) |
| col_limit | input | 9 | Largest column accepted |
| row_limit | input | 8 | Largest row accepted |
| coord_ready | input | 1 | Downstream accepts the offered coordinate |
| coord_valid | output | 1 | A coordinate is offered |
| coord_col | output | 9 | Offered column |
| coord_row | output | 8 | Offered row |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run has completed |

## Verification
The bench first runs a short pass with both limits at zero. Here only the seed state can produce a pixel, which separates the seed and the row bias from everything else and shows the offered coordinate held across several cycles with ready low, followed by a long stretch of rejected states. The main pass is the full 320 by 200 sweep. A bench-side model, written as a bit concatenation rather than a shift-and-mask, predicts on every cycle whether a coordinate is due and which one. Ready is withheld on a fixed cadence, so stall handling is exercised all through the sequence, and a start pulse arrives in mid-run. Distinct coordinates are counted against a full occupancy map, and the step count at the end is compared against the period of the register.

// File: rtl/pixscan_pkg.sv
package pixscan_pkg;
  localparam int STATE_W = 17;
  localparam int COL_W   = 9;
  localparam int ROW_W   = 8;
  localparam logic [STATE_W-1:0] FEEDBACK_MASK = 17'h12000;
  localparam logic [STATE_W-1:0] SEED_VALUE    = 17'h00001;

  typedef enum logic [1:0] {
    PS_IDLE = 2'b00,
    PS_RUN  = 2'b01,
    PS_DONE = 2'b10
  } pixscan_phase_e;
endpackage

// File: rtl/pixscan_lfsr.sv
module pixscan_lfsr #(
  parameter int                 STATE_W = pixscan_pkg::STATE_W,
  parameter logic [STATE_W-1:0] MASK    = pixscan_pkg::FEEDBACK_MASK,
  parameter logic [STATE_W-1:0] SEED    = pixscan_pkg::SEED_VALUE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               adv,
  output logic [STATE_W-1:0] state,
  output logic               seq_end
);
  function automatic logic [STATE_W-1:0] galois_step(input logic [STATE_W-1:0] s);
    logic [STATE_W-1:0] shifted;
    shifted = s >> 1;
    return s[0] ? (shifted ^ MASK) : shifted;
  endfunction

  logic [STATE_W-1:0] state_next;

  always_comb begin
    state_next = galois_step(state);
    seq_end    = (state_next == SEED);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= SEED;
    else if (load) state <= SEED;
    else if (adv)  state <= state_next;
  end

  // R3: a maximal-length register never reaches the all-zero state
  a_r3_state_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
  // R6: no advance means the state holds
  a_r6_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv && !load |=> $stable(state));
endmodule

// File: rtl/pixscan_split.sv
module pixscan_split #(
  parameter int STATE_W = pixscan_pkg::STATE_W,
  parameter int COL_W   = pixscan_pkg::COL_W,
  parameter int ROW_W   = pixscan_pkg::ROW_W
) (
  input  logic [STATE_W-1:0] state,
  input  logic [COL_W-1:0]   col_limit,
  input  logic [ROW_W-1:0]   row_limit,
  output logic [COL_W-1:0]   col,
  output logic [ROW_W-1:0]   row,
  output logic               in_range
);
  localparam int COL_LSB = ROW_W;
  localparam int COL_MSB = ROW_W + COL_W - 1;

  function automatic logic [ROW_W-1:0] row_of(input logic [STATE_W-1:0] s);
    return s[ROW_W-1:0] - ROW_W'(1);
  endfunction

  function automatic logic [COL_W-1:0] col_of(input logic [STATE_W-1:0] s);
    return s[COL_MSB:COL_LSB];
  endfunction

  always_comb begin
    col      = col_of(state);
    row      = row_of(state);
    in_range = (col <= col_limit) && (row <= row_limit);
  end

  initial begin
    a_r4_width_fit: assert (COL_W + ROW_W == STATE_W);
  end
endmodule

// File: rtl/pixscan_ctrl.sv
module pixscan_ctrl
  import pixscan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_range,
  input  logic ready,
  input  logic seq_end,
  output logic load,
  output logic adv,
  output logic valid,
  output logic busy,
  output logic done
);
  pixscan_phase_e phase;
  logic           finish_step;

  always_comb begin
    busy        = (phase == PS_RUN);
    done        = (phase == PS_DONE);
    load        = start && !busy;
    valid       = busy && in_range;
    adv         = busy && (!in_range || ready);
    finish_step = adv && seq_end;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           phase <= PS_IDLE;
    else if (load)        phase <= PS_RUN;
    else if (finish_step) phase <= PS_DONE;
  end

  // R8: done holds until a new start
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);
  // R9: start during a run neither ends nor reloads it
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !finish_step |=> busy);
endmodule

// File: rtl/pixscan_seq.sv
module pixscan_seq
  import pixscan_pkg::*;
#(
  parameter int                 P_STATE_W = STATE_W,
  parameter int                 P_COL_W   = COL_W,
  parameter int                 P_ROW_W   = ROW_W,
  parameter logic [P_STATE_W-1:0] P_MASK  = FEEDBACK_MASK,
  parameter logic [P_STATE_W-1:0] P_SEED  = SEED_VALUE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [P_COL_W-1:0] col_limit,
  input  logic [P_ROW_W-1:0] row_limit,
  input  logic               coord_ready,
  output logic               coord_valid,
  output logic [P_COL_W-1:0] coord_col,
  output logic [P_ROW_W-1:0] coord_row,
  output logic               busy,
  output logic               done
);
  logic [P_STATE_W-1:0] state;
  logic                 seq_end;
  logic                 load;
  logic                 adv;
  logic                 in_range;

  pixscan_lfsr #(.STATE_W(P_STATE_W), .MASK(P_MASK), .SEED(P_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(adv),
    .state(state), .seq_end(seq_end)
  );

  pixscan_split #(.STATE_W(P_STATE_W), .COL_W(P_COL_W), .ROW_W(P_ROW_W)) u_split (
    .state(state), .col_limit(col_limit), .row_limit(row_limit),
    .col(coord_col), .row(coord_row), .in_range(in_range)
  );

  pixscan_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .in_range(in_range),
    .ready(coord_ready), .seq_end(seq_end), .load(load), .adv(adv),
    .valid(coord_valid), .busy(busy), .done(done)
  );

  // R5: only in-limit coordinates are offered
  a_r5_in_limits: assert property (@(posedge clk) disable iff (!rst_n)
    coord_valid |-> (coord_col <= col_limit) && (coord_row <= row_limit));
  // R6: offered coordinate is held while stalled
  a_r6_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    coord_valid && !coord_ready && !start |=> coord_valid && $stable(coord_col) && $stable(coord_row));
  // R7: a rejected state moves on next clock
  a_r7_reject_moves: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !coord_valid |=> !$stable(state));
  // R8: busy and done are exclusive
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  // R2: every run begins at column 0, row 0
  a_r2_first_coord: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> coord_col == '0 && coord_row == '0);
endmodule

// File: tb/test_pixscan_seq.sv
`timescale 1ns/1ps
module test_pixscan_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [8:0] col_limit = '0;
  logic [7:0] row_limit = '0;
  logic       coord_ready = 1'b0;
  logic       coord_valid;
  logic [8:0] coord_col;
  logic [7:0] coord_row;
  logic       busy;
  logic       done;

  int checks = 0;
  int errors = 0;
  int done_rises = 0;
  logic done_q = 1'b0;
  bit seen [0:511][0:255];
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pixscan_seq i_pixscan_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .col_limit(col_limit),
    .row_limit(row_limit), .coord_ready(coord_ready), .coord_valid(coord_valid),
    .coord_col(coord_col), .coord_row(coord_row), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    done_q <= done;
    if (rst_n && done && !done_q) done_rises <= done_rises + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // bench model of one step, written as a bit concatenation
  function automatic logic [16:0] model_next(input logic [16:0] s);
    logic b;
    b = s[0];
    return {b, s[16:15], s[14] ^ b, s[13:1]};
  endfunction

  function automatic bit model_in(input logic [16:0] s, input int cl, input int rl,
                                  output int cx, output int ry);
    cx = int'(s) / 256;
    ry = (int'(s) % 256 + 255) % 256;
    return (cx <= cl) && (ry <= rl);
  endfunction

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "WDOG", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [16:0] mst;
    int steps, pix, dups, cyc, ex, ey;
    bit ein, rd, stepping;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !coord_valid, "R1", "idle after reset",
          {busy, done, coord_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // short pass, both limits zero
    col_limit = 9'd0; row_limit = 8'd0; coord_ready = 1'b0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    check(busy && coord_valid && coord_col == 0 && coord_row == 0, "R2",
          "seed coordinate", {coord_col, coord_row}, 0);
    repeat (3) @(negedge clk);
    check(coord_valid && coord_col == 0 && coord_row == 0, "R6",
          "held while stalled", coord_valid, 1);
    coord_ready = 1'b1;
    @(negedge clk);
    check(!coord_valid && busy, "R7", "state 0x12000 rejected", coord_valid, 0);
    check(coord_col == 9'h120 && coord_row == 8'hFF, "R4",
          "split of 0x12000 with row wrap", {coord_col, coord_row}, {9'h120, 8'hFF});
    coord_ready = 1'b0;
    begin
      int vcount = 0;
      for (int i = 0; i < 20; i++) begin
        if (coord_valid) vcount++;
        @(negedge clk);
      end
      check(vcount == 0, "R5", "nothing offered with zero limits", vcount, 0);
    end
    rst_n = 1'b0; @(negedge clk);
    check(!busy && !done && !coord_valid, "R1", "mid-run reset clears",
          {busy, done, coord_valid}, 0);
    rst_n = 1'b1; @(negedge clk);

    // full pass 320 x 200
    col_limit = 9'd319; row_limit = 8'd199;
    mst = 17'h1; steps = 0; pix = 0; dups = 0; cyc = 0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    begin
      int order_err = 0, state_err = 0;
      forever begin
        ein = model_in(mst, 319, 199, ex, ey);
        if (coord_valid != ein || (ein && (coord_col != ex || coord_row != ey))) begin
          order_err++;
          if (order_err <= 4)
            check(1'b0, "R3", "sequence order", {coord_valid, coord_col, coord_row},
                  {ein, ex[8:0], ey[7:0]});
        end
        if (!busy || done) state_err++;
        rd = (cyc % 7) != 3;
        stepping = !ein || rd;
        if (ein && rd) begin
          if (seen[coord_col][coord_row]) dups++;
          seen[coord_col][coord_row] = 1'b1;
          pix++;
        end
        if (stepping) begin
          mst = model_next(mst);
          steps++;
        end
        coord_ready = rd;
        start = (cyc == 60000); // R9 start during a run
        cyc++;
        @(negedge clk);
        if (stepping && mst == 17'h1) break;
      end
      start = 1'b0;
      check(order_err == 0, "R3", "per-cycle order mismatches (R4 R5 R7 R9)", order_err, 0);
      check(state_err == 0, "R9", "busy stays high during run", state_err, 0);
    end
    check(done && !busy && !coord_valid, "R8", "done after return to seed",
          {done, busy, coord_valid}, 4);
    check(steps == 131071, "R8", "steps in one run", steps, 131071);
    check(pix == 64000, "R10", "coordinates offered", pix, 64000);
    check(dups == 0, "R10", "duplicate coordinates", dups, 0);
    repeat (5) @(negedge clk);
    check(done && !busy, "R8", "done stays high", done, 1);
    check(done_rises == 1, "R8", "done rises exactly once", done_rises, 1);
    start = 1'b1; @(negedge clk); start = 1'b0;
    check(busy && !done && coord_valid && coord_col == 0 && coord_row == 0, "R8",
          "restart clears done", {busy, done}, 2);
    rst_n = 1'b0; @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule